// File: doc/BRIEF.md
# Permission-Checking Address Translation Cache

This block turns a 32-bit virtual address into a physical address for 4 KiB pages. It holds eight page mappings in a fully associative store. Each stored mapping keeps its frame number and a set of page rights: readable, writable, executable, user-accessible, referenced and modified. Every request carries an access kind and a privilege mode. In the same cycle the block answers with exactly one of three outcomes: a translated address, a protection fault, or a miss.

A miss raises a walk request toward an external page-table walker. The block then holds off new requests until the walker returns a fill. The fill is stored in a free slot when one exists. When all slots are taken, the slot to replace comes from a free-running pseudo-random sequence. A store to a page whose modified bit is clear is answered as a miss, so the walker can mark the page modified in memory before the store goes ahead. A flush input empties the store in one cycle.

Top module: `tlb_perm`

## Requirements
- R1: A lookup that finds its page number and passes every check raises `rsp_hit` in the same cycle, with `rsp_pa` equal to the stored frame number joined above the unchanged low 12 address bits.
- R2: A lookup that finds no valid slot for its page number raises `rsp_miss` and `walk_req` in the same cycle, with `walk_vpn` equal to address bits 31:12.
- R3: From the cycle after a miss until a cycle with `fill_valid` high, `req_stall` is high, no outcome flag rises for any request, and `walk_req` stays high with an unchanged `walk_vpn`. Requests are accepted again in the cycle after the fill.
- R4: After a fill, a lookup of the pending page number hits and returns the filled frame number.
- R5: `fill_perm` bit 0 grants read, bit 1 grants write, bit 2 grants execute, bit 3 allows user mode, bit 4 is the referenced flag and bit 5 is the modified flag. `req_acc` selects 0 for read, 1 for write and 2 for execute; value 3 is always denied. A hit without the right for the requested access gives `rsp_fault`.
- R6: With `req_user` high, a hit on a page whose user bit is clear gives `rsp_fault`. With `req_user` low, the user bit is ignored.
- R7: The protection checks are applied before the modified-bit rule. A fault starts no walk and causes no stall.
- R8: A write that passes the protection checks on a page whose modified bit is clear is answered as a miss. The fill for that miss overwrites the same slot, so the new frame number is returned afterwards.
- R9: Up to eight distinct pages filled after a flush are all kept, because free slots are always used before any valid slot is replaced.
- R10: A fill into a full store replaces one slot chosen by a pseudo-random sequence, and the newly filled page then hits.
- R11: A cycle with `flush` high leaves every slot invalid in the next cycle. A fill in the same cycle as a flush still ends the walk, but its mapping is not stored.
- R12: After reset the store is empty, `req_stall` and `walk_req` are low, and no outcome flag rises without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every stored mapping |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| req_stall | output | 1 | A walk is outstanding, so requests are not taken |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | Protection violation |
| rsp_miss | output | 1 | Mapping absent or modified bit must be set |
| rsp_pa | output | 32 | Physical address, valid together with rsp_hit |
| walk_req | output | 1 | Page-table walk wanted |
| walk_vpn | output | 20 | Page number for the walker |
| fill_valid | input | 1 | Walker returns a mapping |
| fill_pfn | input | 20 | Returned frame number |
| fill_perm | input | 6 | Returned rights and flags, laid out as in R5 |

## Verification
The bench builds the block with its default values: eight slots, 20-bit page and frame numbers, and an 8-bit pseudo-random sequence. With only eight slots and four rights bits, the bench can sweep every combination of the four rights, the modified flag, the three access kinds and both privilege modes. It can also fill the store completely and push it into replacement within a few hundred cycles. Since the replacement choice cannot be predicted from outside, the bench checks what must hold for any choice: the new page is present, and at least one older page is gone.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PERM_W = 6;

  // Rights and flags of a page; bit 0 is read, bit 5 is modified.
  typedef struct packed {
    logic dirty;
    logic accessed;
    logic user_ok;
    logic exec;
    logic wr;
    logic rd;
  } perm_t;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // Rights check: the access kind must be granted and the mode allowed.
  function automatic logic perm_allows(perm_t p, logic [1:0] acc, logic user_mode);
    logic need;
    case (acc)
      ACC_LOAD:  need = p.rd;
      ACC_STORE: need = p.wr;
      ACC_FETCH: need = p.exec;
      default:   need = 1'b0;
    endcase
    return need && (!user_mode || p.user_ok);
  endfunction

  // A permitted store to a clean page must go back to the walker.
  function automatic logic needs_mark_walk(perm_t p, logic [1:0] acc);
    return (acc == ACC_STORE) && !p.dirty;
  endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 'hB8,
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= {{(W-1){1'b0}}, 1'b1};
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else state_q <= state_q >> 1;
  end

  assign rnd = state_q[OUT_W-1:0];

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R10

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          hit_any,
  output logic [IDX_W-1:0]              hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   rnd,
  input  logic               same_hit,
  input  logic [IDX_W-1:0]   same_idx,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               has_free
);
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  // Overwrite a matching slot, else the lowest free slot, else a random one.
  always_comb begin
    if (same_hit)      pick_idx = same_idx;
    else if (has_free) pick_idx = free_idx;
    else               pick_idx = IDX_W'(32'(rnd) % ENTRIES);
  end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES = 8,
  parameter int LFSR_W = 8,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PFN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_va,
  input  logic [1:0]                  req_acc,
  input  logic                        req_user,
  output logic                        req_stall,
  output logic                        rsp_hit,
  output logic                        rsp_fault,
  output logic                        rsp_miss,
  output logic [PA_W-1:0]             rsp_pa,
  output logic                        walk_req,
  output logic [VPN_W-1:0]            walk_vpn,
  input  logic                        fill_valid,
  input  logic [PFN_W-1:0]            fill_pfn,
  input  logic [tlb_pkg::PERM_W-1:0]  fill_perm
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  perm_t                         perm_q [ENTRIES];
  logic                          busy_q;
  logic [VPN_W-1:0]              pend_vpn_q;

  // Named internal events
  logic [VPN_W-1:0]   req_vpn, key;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, lookup_en, perm_ok, mark_walk;
  logic               evt_hit, evt_fault, evt_miss;
  logic               fill_fire, install, has_free;
  logic [IDX_W-1:0]   hit_idx, vic_idx, rnd;
  perm_t              hit_perm;

  assign req_vpn   = req_va[VA_W-1:PAGE_BITS];
  assign key       = busy_q ? pend_vpn_q : req_vpn;
  assign lookup_en = req_valid && !busy_q;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid(valid_q), .tags(vpn_q), .key(key),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'('hB8)), .OUT_W(IDX_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid(valid_q), .rnd(rnd), .same_hit(hit_any), .same_idx(hit_idx),
    .pick_idx(vic_idx), .has_free(has_free)
  );

  assign hit_perm  = perm_q[hit_idx];
  assign perm_ok   = perm_allows(hit_perm, req_acc, req_user);
  assign mark_walk = needs_mark_walk(hit_perm, req_acc);

  assign evt_fault = lookup_en && hit_any && !perm_ok;
  assign evt_hit   = lookup_en && hit_any && perm_ok && !mark_walk;
  assign evt_miss  = lookup_en && (!hit_any || (perm_ok && mark_walk));

  assign rsp_hit   = evt_hit;
  assign rsp_fault = evt_fault;
  assign rsp_miss  = evt_miss;
  assign rsp_pa    = evt_hit ? {pfn_q[hit_idx], req_va[PAGE_BITS-1:0]} : '0;
  assign req_stall = busy_q;
  assign walk_req  = evt_miss || busy_q;
  assign walk_vpn  = busy_q ? pend_vpn_q : (evt_miss ? req_vpn : '0);

  assign fill_fire = fill_valid && busy_q;
  assign install   = fill_fire && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (install) begin
      valid_q[vic_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      vpn_q[vic_idx]  <= pend_vpn_q;
      pfn_q[vic_idx]  <= fill_pfn;
      perm_q[vic_idx] <= perm_t'(fill_perm);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_vpn_q <= '0;
    end else if (fill_fire) begin
      busy_q     <= 1'b0;
    end else if (evt_miss) begin
      busy_q     <= 1'b1;
      pend_vpn_q <= req_vpn;
    end
  end

  AST_MISS_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |=> busy_q && walk_req); // R2
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(rsp_hit || rsp_fault || rsp_miss)); // R3
  AST_WALK_VPN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(walk_vpn)); // R3
  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    install |=> valid_q[$past(vic_idx)]); // R4
  AST_FAULT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> !busy_q); // R7
  AST_NO_DUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    install && !hit_any && has_free |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0); // R11
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_fault, rsp_miss})); // R1

endmodule

// File: tb/tlb_perm_bench.sv
`timescale 1ns/1ps
module tlb_perm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        req_stall, rsp_hit, rsp_fault, rsp_miss, walk_req;
  logic [31:0] rsp_pa;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_pfn = '0;
  logic [5:0]  fill_perm = '0;

  int total = 0;
  int bad = 0;

  logic        c_hit, c_fault, c_miss, c_wreq, c_stall_after;
  logic [31:0] c_pa;
  logic [19:0] c_wvpn;

  always #5 clk = ~clk;

  tlb_perm u_tlb_perm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_va(req_va), .req_acc(req_acc), .req_user(req_user),
    .req_stall(req_stall), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .walk_req(walk_req),
    .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One request cycle; outcomes sampled mid-cycle, stall sampled after the edge.
  task automatic probe(logic [19:0] vpn, logic [11:0] off, logic [1:0] acc, logic usr);
    @(negedge clk);
    req_valid = 1'b1; req_va = {vpn, off}; req_acc = acc; req_user = usr;
    #1;
    c_hit = rsp_hit; c_fault = rsp_fault; c_miss = rsp_miss;
    c_pa = rsp_pa; c_wreq = walk_req; c_wvpn = walk_vpn;
    @(posedge clk); #1;
    req_valid = 1'b0;
    c_stall_after = req_stall;
  endtask

  task automatic fill(logic [19:0] pfn, logic [5:0] perm, logic with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_pfn = pfn; fill_perm = perm; flush = with_flush;
    @(posedge clk); #1;
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  // Expected outcome from R5..R8: 0 hit, 1 fault, 2 miss.
  function automatic int expect_code(logic [3:0] p, logic d, logic [1:0] acc, logic usr);
    logic need;
    need = (acc == 2'd0) ? p[0] : (acc == 2'd1) ? p[1] : (acc == 2'd2) ? p[2] : 1'b0;
    if (!need || (usr && !p[3])) return 1;
    if (acc == 2'd1 && !d) return 2;
    return 0;
  endfunction

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "stall", req_stall, 0);
    chk("R12", "walk_req", walk_req, 0);
    chk("R12", "flags", {rsp_hit, rsp_fault, rsp_miss}, 0);
    probe(20'h00042, 12'h000, 2'd0, 1'b0);
    chk("R12", "first lookup misses", c_miss, 1);
    chk("R2", "walk_vpn", c_wvpn, 20'h00042);
    chk("R2", "walk_req", c_wreq, 1);
    chk("R3", "stall after miss", c_stall_after, 1);

    // R3 stall while walk outstanding
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h77777_123; req_acc = 2'd0; #1;
    chk("R3", "stall held", req_stall, 1);
    chk("R3", "no outcome", {rsp_hit, rsp_fault, rsp_miss}, 0);
    chk("R3", "walk held", {walk_req, walk_vpn}, {1'b1, 20'h00042});
    @(posedge clk); #1 req_valid = 1'b0;
    fill(20'hABCDE, 6'b110001, 1'b0);
    chk("R3", "stall released", req_stall, 0);
    probe(20'h00042, 12'h9F3, 2'd0, 1'b1);
    chk("R4", "fill hits", c_hit, 0); // user bit clear, user mode
    chk("R6", "user fault", c_fault, 1);
    chk("R7", "fault no stall", c_stall_after, 0);
    probe(20'h00042, 12'h9F3, 2'd0, 1'b0);
    chk("R4", "hit after fill", c_hit, 1);
    chk("R1", "pa join", c_pa, 32'hABCDE_9F3);

    // R5 R6 R7 R8 exhaustive rights sweep
    for (int p = 0; p < 16; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int a = 0; a < 3; a++) begin
          for (int u = 0; u < 2; u++) begin
            logic [19:0] vpn, pfn;
            logic [11:0] off;
            int ec;
            vpn = 20'(p * 97 + d * 13 + a * 5 + u + 20'h10000);
            pfn = vpn ^ 20'hA5A5A;
            off = 12'(p * 37 + d * 5 + a * 101 + u * 2000);
            do_flush();
            probe(vpn, 12'h000, 2'd0, 1'b0);
            chk("R11", "miss after flush", c_miss, 1);
            fill(pfn, {d[0], 1'b1, 4'(p)}, 1'b0);
            probe(vpn, off, 2'(a), u[0]);
            ec = expect_code(4'(p), d[0], 2'(a), u[0]);
            chk("R5", "hit flag", c_hit, ec == 0);
            chk("R6", "fault flag", c_fault, ec == 1);
            chk("R8", "miss flag", c_miss, ec == 2);
            if (ec == 0) chk("R1", "pa", c_pa, {pfn, off});
            if (ec == 1) chk("R7", "fault leaves no stall", c_stall_after, 0);
            if (ec == 2) fill(pfn, {d[0], 1'b1, 4'(p)}, 1'b0);
          end
        end
      end
    end

    // R8 clean-page store then overwrite in place
    do_flush();
    probe(20'h0BEEF, 12'h0, 2'd0, 1'b0);
    fill(20'h11111, 6'b010011, 1'b0);
    probe(20'h0BEEF, 12'h456, 2'd1, 1'b0);
    chk("R8", "clean store misses", c_miss, 1);
    chk("R8", "walk vpn", c_wvpn, 20'h0BEEF);
    fill(20'h22222, 6'b110011, 1'b0);
    probe(20'h0BEEF, 12'h456, 2'd1, 1'b0);
    chk("R8", "store hits after mark", c_hit, 1);
    chk("R8", "new frame", c_pa, 32'h22222_456);

    // R9 eight pages all kept (one already present)
    for (int i = 1; i < 8; i++) begin
      probe(20'(20'h30000 + i), 12'h0, 2'd0, 1'b0);
      fill(20'(20'h50000 + i), 6'b110001, 1'b0);
    end
    probe(20'h0BEEF, 12'h001, 2'd0, 1'b0);
    chk("R9", "first page kept", c_pa, 32'h22222_001);
    for (int i = 1; i < 8; i++) begin
      probe(20'(20'h30000 + i), 12'h0AB, 2'd0, 1'b0);
      chk("R9", "page kept", {c_hit, c_pa}, {1'b1, 20'(20'h50000 + i), 12'h0AB});
    end

    // R10 replacement when full
    begin
      int misses;
      misses = 0;
      probe(20'h3FFFF, 12'h0, 2'd0, 1'b0);
      chk("R10", "ninth misses", c_miss, 1);
      fill(20'h6FFFF, 6'b110001, 1'b0);
      probe(20'h3FFFF, 12'h321, 2'd0, 1'b0);
      chk("R10", "ninth present", c_pa, 32'h6FFFF_321);
      for (int i = 1; i < 8; i++) begin
        probe(20'(20'h30000 + i), 12'h0, 2'd0, 1'b0);
        if (c_miss) begin
          misses++;
          fill(20'(20'h50000 + i), 6'b110001, 1'b0);
        end
      end
      probe(20'h0BEEF, 12'h0, 2'd0, 1'b0);
      if (c_miss) begin
        misses++;
        fill(20'h22222, 6'b110001, 1'b0);
      end
      chk("R10", "some page replaced", misses >= 1, 1);
    end

    // R11 flush clears, flush with fill drops the fill
    do_flush();
    probe(20'h3FFFF, 12'h0, 2'd0, 1'b0);
    chk("R11", "flushed page misses", c_miss, 1);
    fill(20'h12345, 6'b110001, 1'b1);
    chk("R11", "walk ended", req_stall, 0);
    probe(20'h3FFFF, 12'h0, 2'd0, 1'b0);
    chk("R11", "dropped fill", c_miss, 1);
    fill(20'h12345, 6'b110001, 1'b0);
    probe(20'h3FFFF, 12'hFFF, 2'd2, 1'b0);
    chk("R5", "exec without right", c_fault, 1);
    probe(20'h3FFFF, 12'hFFF, 2'd3, 1'b0);
    chk("R5", "code 3 denied", c_fault, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule